// File: doc/BRIEF.md
# Threshold Alert and Conversion-Ready Logic

This block sits behind the measurement core of a current and power monitor and decides when the single alert pin is driven. Each shunt-voltage conversion, each bus-voltage conversion and each power result arrives with its own one-cycle strobe. The block checks that individual result against one shared limit register, with no averaging, so a short excursion is caught even when the averaged result never crosses the limit.

A control register picks one of five limit checks: shunt above, shunt below, bus above, bus below, or power above. When several enable bits are set, the most significant one is the only active check. The outcome is held in a fault flag. A second flag records each conversion-ready strobe, and that flag can also drive the pin. A latch option holds the fault flag until software reads the control register or writes the configuration register. A polarity bit picks the active level of the open-drain pin. The pin is modelled as an output-enable: when it is 1, the pad is pulled low.

A small register port carries the register traffic. Address 0 is the configuration register, where only the write event matters. Address 1 is the control and status register. Address 2 is the limit register. Read data is registered.

Top module: `alert_monitor`

## Requirements
- R1: After reset, the control and limit registers and both flags are zero, and `alert_oe` is 0.
- R2: When the shunt-above check is active (control bit 15), each shunt strobe sets the fault flag if the sample is greater than the limit, both taken as signed two's complement. An equal sample does not set it.
- R3: When the shunt-below check is active (bit 14), each shunt strobe sets the fault flag if the sample is less than the limit, both signed.
- R4: The bus-above check (bit 13) tests unsigned greater-than, and the bus-below check (bit 12) tests unsigned less-than. Both are evaluated only on a bus strobe.
- R5: The power-above check (bit 11) tests unsigned greater-than on each power strobe.
- R6: Only the highest set bit among bits 15 to 11 is active. Lower enable bits, and strobes from sources the active check does not use, leave the fault flag unchanged.
- R7: With latching off (bit 0 = 0), the fault flag takes the result of the latest strobe of the active check.
- R8: With latching on (bit 0 = 1), a set fault flag stays set until a read of address 1 or a write to address 0.
- R9: A write to address 0 clears both flags, whether latching is on or off.
- R10: A conversion-ready strobe sets the ready flag. A read of address 1 or a write to address 0 clears it.
- R11: A read of address 1 returns bits 15..10, 1 and 0 as written, the fault flag in bit 4, the ready flag in bit 3, and zero elsewhere. A read of address 2 returns the limit. Read data appears in the cycle after `rd_en`.
- R12: The pin is active when the fault flag is set and any check is enabled, or when the ready flag is set and bit 10 is 1.
- R13: With bit 1 = 0, `alert_oe` equals the active state. With bit 1 = 1, `alert_oe` is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shunt_vld | input | 1 | Shunt conversion done strobe |
| shunt_val | input | DW | Shunt sample, signed |
| bus_vld | input | 1 | Bus conversion done strobe |
| bus_val | input | DW | Bus sample, unsigned |
| pwr_vld | input | 1 | Power result strobe |
| pwr_val | input | DW | Power result, unsigned |
| cnv_rdy | input | 1 | Conversion-ready strobe |
| wr_en | input | 1 | Register write |
| rd_en | input | 1 | Register read |
| addr | input | 2 | Register address (0 config, 1 control/status, 2 limit) |
| wdata | input | DW | Write data |
| rdata | output | DW | Registered read data |
| alert_oe | output | 1 | Open-drain pull-down enable for the alert pad |

## Verification
The bench builds the block with the default DW = 16. At this width the signed boundary at 0x8000 and the unsigned extreme at 0xFFFF can be reached directly, so one pattern is a large unsigned value that is negative when read as signed. Each table vector isolates one check under one enable pattern. Directed cases cover holding against clearing of the latched flag, the ready flag with and without its enable bit, and both polarities.

// File: rtl/alert_monitor.sv
`timescale 1ns/1ps
module alert_monitor #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shunt_vld,
  input  logic [DW-1:0] shunt_val,
  input  logic          bus_vld,
  input  logic [DW-1:0] bus_val,
  input  logic          pwr_vld,
  input  logic [DW-1:0] pwr_val,
  input  logic          cnv_rdy,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          alert_oe
);
  localparam logic [1:0]  A_CFG  = 2'd0;
  localparam logic [1:0]  A_CTL  = 2'd1;
  localparam logic [1:0]  A_LIM  = 2'd2;
  localparam logic [15:0] WMASK  = 16'hFC03;

  logic [15:0]   ctl_q;
  logic [DW-1:0] lim_q;
  logic          aff_q, cvrf_q;

  wire cfg_wr = wr_en & (addr == A_CFG);
  wire ctl_rd = rd_en & (addr == A_CTL);
  wire latch  = ctl_q[0];
  wire pol    = ctl_q[1];
  wire rdy_en = ctl_q[10];

  wire f_sol = ctl_q[15];
  wire f_sul = ctl_q[14] & ~ctl_q[15];
  wire f_bol = ctl_q[13] & ~|ctl_q[15:14];
  wire f_bul = ctl_q[12] & ~|ctl_q[15:13];
  wire f_pol = ctl_q[11] & ~|ctl_q[15:12];
  wire f_any = |ctl_q[15:11];

  wire s_gt = $signed(shunt_val) > $signed(lim_q);
  wire s_lt = $signed(shunt_val) < $signed(lim_q);
  wire b_gt = bus_val > lim_q;
  wire b_lt = bus_val < lim_q;
  wire p_gt = pwr_val > lim_q;

  wire upd = (shunt_vld & (f_sol | f_sul)) | (bus_vld & (f_bol | f_bul)) | (pwr_vld & f_pol);
  wire hit = (shunt_vld & ((f_sol & s_gt) | (f_sul & s_lt)))
           | (bus_vld & ((f_bol & b_gt) | (f_bul & b_lt)))
           | (pwr_vld & f_pol & p_gt);

  logic aff_n;
  always_comb begin
    aff_n = (cfg_wr | (ctl_rd & latch)) ? 1'b0 : aff_q;
    if (upd) aff_n = latch ? (aff_n | hit) : hit;
  end

  wire [15:0] ctl_view = (ctl_q & WMASK) | {11'd0, aff_q, cvrf_q, 3'd0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      lim_q  <= '0;
      aff_q  <= 1'b0;
      cvrf_q <= 1'b0;
      rdata  <= '0;
    end else begin
      aff_q <= aff_n;
      if (cnv_rdy)              cvrf_q <= 1'b1;
      else if (cfg_wr | ctl_rd) cvrf_q <= 1'b0;
      if (wr_en && addr == A_CTL) ctl_q <= wdata[15:0] & WMASK;
      if (wr_en && addr == A_LIM) lim_q <= wdata;
      if (rd_en) begin
        case (addr)
          A_CTL:   rdata <= DW'(ctl_view);
          A_LIM:   rdata <= lim_q;
          default: rdata <= '0;
        endcase
      end
    end
  end

  wire active = (aff_q & f_any) | (cvrf_q & rdy_en);
  assign alert_oe = active ^ pol;
endmodule

// File: rtl/alert_monitor_chk.sv
`timescale 1ns/1ps
module alert_monitor_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        shunt_vld,
  input logic        bus_vld,
  input logic        pwr_vld,
  input logic        cnv_rdy,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [15:0] ctl,
  input logic        aff,
  input logic        cvrf,
  input logic        alert_oe
);
  wire any_stb = shunt_vld | bus_vld | pwr_vld;
  wire cfgw    = wr_en & (addr == 2'd0);
  wire ctlr    = rd_en & (addr == 2'd1);

  p_cfg_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgw && !any_stb) |=> !aff);
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (aff && ctl[0] && !cfgw && !ctlr) |=> aff);
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlr && ctl[0] && !any_stb) |=> !aff);
  p_ready_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_rdy |=> cvrf);
  p_no_strobe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_stb && !cfgw && !ctlr) |=> $stable(aff));
  p_idle_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl[15:10] == 6'd0 && !ctl[1]) |-> !alert_oe);
endmodule

bind alert_monitor alert_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shunt_vld(shunt_vld), .bus_vld(bus_vld),
  .pwr_vld(pwr_vld), .cnv_rdy(cnv_rdy), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .ctl(ctl_q), .aff(aff_q), .cvrf(cvrf_q), .alert_oe(alert_oe)
);

// File: tb/alert_monitor_tb.sv
`timescale 1ns/1ps
module alert_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shunt_vld = 0, bus_vld = 0, pwr_vld = 0, cnv_rdy = 0;
  logic [15:0] shunt_val = 0, bus_val = 0, pwr_val = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [1:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        alert_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  alert_monitor #(.DW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .shunt_vld(shunt_vld), .shunt_val(shunt_val),
    .bus_vld(bus_vld), .bus_val(bus_val), .pwr_vld(pwr_vld), .pwr_val(pwr_val),
    .cnv_rdy(cnv_rdy), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .alert_oe(alert_oe)
  );

  // {req, ctl, limit, src(0 shunt,1 bus,2 power), sample, expected fault}
  localparam int NV = 14;
  localparam logic [54:0] VEC [NV] = '{
    {4'd2,  16'h8000, 16'd100,  2'd0, 16'd101,  1'b1},  // R2 above
    {4'd2,  16'h8000, 16'd100,  2'd0, 16'd100,  1'b0},  // R2 equal
    {4'd2,  16'h8000, 16'hFFF0, 2'd0, 16'hFFF8, 1'b1},  // R2 signed negatives
    {4'd2,  16'h8000, 16'd5,    2'd0, 16'h8000, 1'b0},  // R2 most negative
    {4'd3,  16'h4000, 16'd0,    2'd0, 16'hFFFF, 1'b1},  // R3 below
    {4'd4,  16'h2000, 16'h7000, 2'd1, 16'h9000, 1'b1},  // R4 unsigned above
    {4'd4,  16'h1000, 16'h0100, 2'd1, 16'h00FF, 1'b1},  // R4 below
    {4'd4,  16'h1000, 16'h0100, 2'd1, 16'h0100, 1'b0},  // R4 equal
    {4'd5,  16'd2048, 16'd1000, 2'd2, 16'd1001, 1'b1},  // R5 power above
    {4'd6,  16'hC000, 16'd100,  2'd0, 16'd50,   1'b0},  // R6 lower bit ignored
    {4'd6,  16'h8800, 16'd0,    2'd2, 16'hFFFF, 1'b0},  // R6 power masked
    {4'd6,  16'h2000, 16'd0,    2'd0, 16'h7FFF, 1'b0},  // R6 foreign source
    {4'd13, 16'h8002, 16'd100,  2'd0, 16'd200,  1'b1},  // R13 inverted, active
    {4'd13, 16'h8002, 16'd100,  2'd0, 16'd50,   1'b0}   // R13 inverted, idle
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic stb(input logic [1:0] src, input logic [15:0] v);
    @(negedge clk);
    case (src)
      2'd0: begin shunt_vld = 1; shunt_val = v; end
      2'd1: begin bus_vld = 1; bus_val = v; end
      default: begin pwr_vld = 1; pwr_val = v; end
    endcase
    @(negedge clk); shunt_vld = 0; bus_vld = 0; pwr_vld = 0;
  endtask

  task automatic rdy_pulse();
    @(negedge clk); cnv_rdy = 1;
    @(negedge clk); cnv_rdy = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    check("R1 oe", {15'd0, alert_oe}, 16'd0);
    rst_n = 1;
    rd(2'd1, d); check("R1 ctl", d, 16'h0000);
    rd(2'd2, d); check("R1 lim", d, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [54:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[54:51], i);
      wr(2'd0, 16'h0);
      wr(2'd1, v[50:35]);
      wr(2'd2, v[34:19]);
      stb(v[18:17], v[16:1]);
      check({tg, " oe"}, {15'd0, alert_oe}, {15'd0, v[0] ^ v[36]});
      rd(2'd1, d);
      check({tg, " flag"}, {15'd0, d[4]}, {15'd0, v[0]});
    end

    // R7 tracking without latch
    wr(2'd0, 0); wr(2'd1, 16'h8000); wr(2'd2, 16'd100);
    stb(2'd0, 16'd200); check("R7 set", {15'd0, alert_oe}, 16'd1);
    stb(2'd0, 16'd10);  check("R7 follow", {15'd0, alert_oe}, 16'd0);

    // R8 latch hold, then read clears
    wr(2'd1, 16'h8001);
    stb(2'd0, 16'd200); stb(2'd0, 16'd10);
    check("R8 hold", {15'd0, alert_oe}, 16'd1);
    rd(2'd1, d);
    check("R8 read flag", {15'd0, d[4]}, 16'd1);
    check("R8 read clears", {15'd0, alert_oe}, 16'd0);
    // R9 config write clears the latched flag
    stb(2'd0, 16'd200);
    wr(2'd0, 16'h0);
    check("R9 clear", {15'd0, alert_oe}, 16'd0);

    // R10 ready flag without its enable bit
    wr(2'd1, 16'h0000); rdy_pulse();
    check("R10 no enable", {15'd0, alert_oe}, 16'd0);
    rd(2'd1, d); check("R10 flag", d, 16'h0008);
    rd(2'd1, d); check("R10 cleared", d, 16'h0000);
    // R12 ready drives pin when enabled
    wr(2'd1, 16'h0400); rdy_pulse();
    check("R12 ready pin", {15'd0, alert_oe}, 16'd1);
    // R11 both sources visible in status
    wr(2'd1, 16'h8400); wr(2'd2, 16'd100); stb(2'd0, 16'd300);
    rd(2'd1, d); check("R11 status", d, 16'h8418);
    check("R11 ready cleared", {15'd0, alert_oe}, 16'd1);
    wr(2'd0, 0);
    wr(2'd1, 16'hFFFF); rd(2'd1, d); check("R11 mask", d, 16'hFC03);
    wr(2'd2, 16'hA5C3); rd(2'd2, d); check("R11 limit", d, 16'hA5C3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule